// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block passes 8-bit data between two buses, A and B, in the direction set by a direction input. Each bus has its own storage register, and each register samples its bus on the rising edge of its own capture clock. For each direction, a select input picks the source of the outgoing data. It can take the live data from the opposite bus, which passes through combinationally. It can also take the value held in that bus's register.

An active-low output enable can release both buses at once. Each three-state pad is modelled as three ports: an input, an output and an output enable. A bus that is not driven shows zero on its output port. Both registers keep capturing when the buses are released. They also keep capturing while their own bus is being driven by the block. An active-low asynchronous reset clears both registers.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While rst_ni is low, both storage registers clear to zero. Stored-mode output is then 8'h00 in either direction.
- R2: The A register loads a_pad_i on each rising edge of a_clk_i. It holds its value when a_pad_i changes with no edge.
- R3: The B register loads b_pad_i on each rising edge of b_clk_i. It holds its value when b_pad_i changes with no edge.
- R4: When B is driven and ab_stored_i is 1, b_pad_o equals the A register.
- R5: When B is driven and ab_stored_i is 0, b_pad_o equals a_pad_i, with no clock needed.
- R6: When A is driven, a_pad_o equals the B register if ba_stored_i is 1, and b_pad_i if ba_stored_i is 0.
- R7: When oe_ni is 0, dir_i = 1 drives B only (b_oe_o = 1, a_oe_o = 0). When oe_ni is 0, dir_i = 0 drives A only (a_oe_o = 1, b_oe_o = 0).
- R8: When oe_ni is 1, neither bus is driven. Both registers still capture on their clocks.
- R9: Whenever a pad's output enable is 0, that pad's data output is 8'h00.
- R10: While B is driven, a rising edge of b_clk_i stores the value present on b_pad_i. While b_pad_o is showing the A register, an a_clk_i edge changes b_pad_o only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset of both registers, active low |
| a_clk_i | input | 1 | Capture clock of the A register, rising edge |
| b_clk_i | input | 1 | Capture clock of the B register, rising edge |
| dir_i | input | 1 | 1: A toward B, 0: B toward A |
| oe_ni | input | 1 | Output enable, active low |
| ab_stored_i | input | 1 | Source toward B: 0 live A, 1 A register |
| ba_stored_i | input | 1 | Source toward A: 0 live B, 1 B register |
| a_pad_i | input | 8 | Value seen on bus A |
| a_pad_o | output | 8 | Value driven onto bus A |
| a_oe_o | output | 1 | Drive enable for bus A |
| b_pad_i | input | 8 | Value seen on bus B |
| b_pad_o | output | 8 | Value driven onto bus B |
| b_oe_o | output | 1 | Drive enable for bus B |

## Verification
The two functions that can fall in the same cycle are capture and stored-mode transmission. One case is a register loading on its clock edge while its old contents are being sent out. The other is a register sampling the bus the block itself is driving. The bench holds b_pad_o on the A register, changes a_pad_i, and confirms the old value before the a_clk_i edge and the new value after it. It also drives B from live A data, feeds that value back onto b_pad_i, clocks the B register, and reads the stored value back through the A side.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int DATA_W = 8;
  localparam int LANES  = 2;   // lane 0: A toward B, lane 1: B toward A

  typedef logic [DATA_W-1:0] data_t;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;
endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_path_sel.sv
module xcvr_path_sel
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  src_e         src_i,
  input  logic         drive_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] pad_o
);
  logic [W-1:0] pick;

  always_comb begin
    unique case (src_i)
      SRC_STORED: pick = stored_i;
      default:    pick = live_i;
    endcase
  end

  // undriven pad parks at zero
  assign pad_o = pick & {W{drive_i}};
endmodule

// File: rtl/xcvr_dir_ctl.sv
module xcvr_dir_ctl (
  input  logic oe_ni,
  input  logic dir_i,
  output logic a_oe_o,
  output logic b_oe_o
);
  logic en;

  assign en     = ~oe_ni;
  assign b_oe_o = en &  dir_i;
  assign a_oe_o = en & ~dir_i;
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         rst_ni,
  input  logic         a_clk_i,
  input  logic         b_clk_i,
  input  logic         dir_i,
  input  logic         oe_ni,
  input  logic         ab_stored_i,
  input  logic         ba_stored_i,
  input  logic [W-1:0] a_pad_i,
  output logic [W-1:0] a_pad_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_pad_i,
  output logic [W-1:0] b_pad_o,
  output logic         b_oe_o
);
  logic [LANES-1:0] cap_clk;
  logic [LANES-1:0] dst_oe;
  logic [LANES-1:0] sel;
  logic [W-1:0]     src_bus [LANES];
  logic [W-1:0]     q       [LANES];
  logic [W-1:0]     out_bus [LANES];
  logic [W-1:0]     a_q;
  logic [W-1:0]     b_q;

  xcvr_dir_ctl u_dir (
    .oe_ni  (oe_ni),
    .dir_i  (dir_i),
    .a_oe_o (a_oe_o),
    .b_oe_o (b_oe_o)
  );

  assign cap_clk    = {b_clk_i, a_clk_i};
  assign sel        = {ba_stored_i, ab_stored_i};
  assign dst_oe     = {a_oe_o, b_oe_o};
  assign src_bus[0] = a_pad_i;
  assign src_bus[1] = b_pad_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    xcvr_store_reg #(.W(W)) u_store (
      .clk_i  (cap_clk[l]),
      .rst_ni (rst_ni),
      .d_i    (src_bus[l]),
      .q_o    (q[l])
    );

    xcvr_path_sel #(.W(W)) u_sel (
      .src_i    (src_e'(sel[l])),
      .drive_i  (dst_oe[l]),
      .live_i   (src_bus[l]),
      .stored_i (q[l]),
      .pad_o    (out_bus[l])
    );
  end

  assign b_pad_o = out_bus[0];
  assign a_pad_o = out_bus[1];
  assign a_q     = q[0];
  assign b_q     = q[1];
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int W = 8
) (
  input logic         rst_ni,
  input logic         a_clk_i,
  input logic         b_clk_i,
  input logic         oe_ni,
  input logic         ab_stored_i,
  input logic         ba_stored_i,
  input logic [W-1:0] a_pad_i,
  input logic [W-1:0] a_pad_o,
  input logic         a_oe_o,
  input logic [W-1:0] b_pad_i,
  input logic [W-1:0] b_pad_o,
  input logic         b_oe_o,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_q
);
  logic a_seen, b_seen;

  always_ff @(posedge a_clk_i or negedge rst_ni)
    if (!rst_ni) a_seen <= 1'b0; else a_seen <= 1'b1;
  always_ff @(posedge b_clk_i or negedge rst_ni)
    if (!rst_ni) b_seen <= 1'b0; else b_seen <= 1'b1;

  a_r2_a_capture: assert property (@(posedge a_clk_i) disable iff (!rst_ni)
    a_seen |-> a_q == $past(a_pad_i));

  a_r3_b_capture: assert property (@(posedge b_clk_i) disable iff (!rst_ni)
    b_seen |-> b_q == $past(b_pad_i));

  a_r4_stored_to_b: assert property (@(posedge a_clk_i) disable iff (!rst_ni)
    (b_oe_o && ab_stored_i) |-> b_pad_o == a_q);

  a_r5_live_to_b: assert property (@(posedge a_clk_i) disable iff (!rst_ni)
    (b_oe_o && !ab_stored_i) |-> b_pad_o == a_pad_i);

  a_r6_live_to_a: assert property (@(posedge b_clk_i) disable iff (!rst_ni)
    (a_oe_o && !ba_stored_i) |-> a_pad_o == b_pad_i);

  a_r7_one_side: assert property (@(posedge a_clk_i) disable iff (!rst_ni)
    !oe_ni |-> $onehot({a_oe_o, b_oe_o}));

  a_r8_released: assert property (@(posedge b_clk_i) disable iff (!rst_ni)
    oe_ni |-> !a_oe_o && !b_oe_o);

  a_r9_park_b: assert property (@(posedge a_clk_i) disable iff (!rst_ni)
    !b_oe_o |-> b_pad_o == '0);

  a_r9_park_a: assert property (@(posedge b_clk_i) disable iff (!rst_ni)
    !a_oe_o |-> a_pad_o == '0);
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W)) u_chk (.*);

// File: tb/tb_bus_xcvr_reg.sv
`timescale 1ns/1ps
module tb_bus_xcvr_reg;
  logic       clk = 1'b0;
  logic       rst_ni, a_clk_i, b_clk_i, dir_i, oe_ni, ab_stored_i, ba_stored_i;
  logic [7:0] a_pad_i, b_pad_i, a_pad_o, b_pad_o;
  logic       a_oe_o, b_oe_o;
  int         n_chk = 0, n_fail = 0;
  logic       done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bus_xcvr_reg dut (.*);

  typedef struct packed {
    logic oe_n; logic dir; logic sab; logic sba;
    logic [7:0] a_in; logic [7:0] b_in;
    logic x_aoe; logic x_boe; logic [7:0] x_a; logic [7:0] x_b;
    logic [3:0] req;
  } vec_t;

  // registers preloaded: A = 8'h3C, B = 8'hC5
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0, 8'h11,8'h22, 1'b0,1'b1, 8'h00,8'h11, 4'd5},  // R5 live A->B
    '{1'b0,1'b1,1'b1,1'b0, 8'h11,8'h22, 1'b0,1'b1, 8'h00,8'h3C, 4'd4},  // R4 stored A->B
    '{1'b0,1'b0,1'b0,1'b0, 8'h11,8'h5A, 1'b1,1'b0, 8'h5A,8'h00, 4'd6},  // R6 live B->A
    '{1'b0,1'b0,1'b0,1'b1, 8'h11,8'h5A, 1'b1,1'b0, 8'hC5,8'h00, 4'd6},  // R6 stored B->A
    '{1'b1,1'b1,1'b1,1'b0, 8'h11,8'h22, 1'b0,1'b0, 8'h00,8'h00, 4'd8},  // R8 released
    '{1'b1,1'b0,1'b0,1'b0, 8'h11,8'h5A, 1'b0,1'b0, 8'h00,8'h00, 4'd9},  // R9 park
    '{1'b0,1'b1,1'b0,1'b1, 8'hFF,8'h00, 1'b0,1'b1, 8'h00,8'hFF, 4'd7},  // R7 dir high
    '{1'b0,1'b0,1'b1,1'b1, 8'h00,8'h00, 1'b1,1'b0, 8'hC5,8'h00, 4'd7}   // R7 dir low
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse_a();
    #3 a_clk_i = 1'b1; #5 a_clk_i = 1'b0; #3;
  endtask

  task automatic pulse_b();
    #3 b_clk_i = 1'b1; #5 b_clk_i = 1'b0; #3;
  endtask

  task automatic set_ctl(input logic oe_n, input logic dir, input logic sab, input logic sba);
    oe_ni = oe_n; dir_i = dir; ab_stored_i = sab; ba_stored_i = sba; #2;
  endtask

  task automatic preload(input logic [7:0] av, input logic [7:0] bv);
    a_pad_i = av; b_pad_i = bv; #1;
    pulse_a(); pulse_b();
  endtask

  initial begin
    rst_ni = 1'b0; a_clk_i = 1'b0; b_clk_i = 1'b0;
    a_pad_i = 8'hAA; b_pad_i = 8'h55;
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    #20;
    // R1: reset contents visible in stored mode
    chk("R1 stored to B after reset", {24'd0, b_pad_o}, 32'h00);
    set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R1 stored to A after reset", {24'd0, a_pad_o}, 32'h00);
    rst_ni = 1'b1; #5;

    set_ctl(1'b1, 1'b1, 1'b1, 1'b1);
    preload(8'h3C, 8'hC5);

    // R2: no edge, no load
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    a_pad_i = 8'h99; #2;
    chk("R2 hold without edge", {24'd0, b_pad_o}, 32'h3C);
    // R3: no edge, no load
    set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
    b_pad_i = 8'h66; #2;
    chk("R3 hold without edge", {24'd0, a_pad_o}, 32'hC5);

    for (int i = 0; i < NV; i++) begin
      set_ctl(VECS[i].oe_n, VECS[i].dir, VECS[i].sab, VECS[i].sba);
      a_pad_i = VECS[i].a_in; b_pad_i = VECS[i].b_in; #2;
      chk($sformatf("R%0d vector %0d", VECS[i].req, i),
          {14'd0, a_oe_o, b_oe_o, a_pad_o, b_pad_o},
          {14'd0, VECS[i].x_aoe, VECS[i].x_boe, VECS[i].x_a, VECS[i].x_b});
    end

    // R8: capture while both buses released
    set_ctl(1'b1, 1'b1, 1'b1, 1'b1);
    a_pad_i = 8'h77; b_pad_i = 8'h88; #1;
    pulse_a(); pulse_b();
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R8 A captured while released", {24'd0, b_pad_o}, 32'h77);
    set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8 B captured while released", {24'd0, a_pad_o}, 32'h88);

    // R10: stored value sent out, register reloads on the same edge
    set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
    a_pad_i = 8'hE1; #2;
    chk("R10 old value before edge", {24'd0, b_pad_o}, 32'h77);
    pulse_a();
    chk("R10 new value after edge", {24'd0, b_pad_o}, 32'hE1);

    // R10 / R3: B driven from live A, bus value fed back and captured
    set_ctl(1'b0, 1'b1, 1'b0, 1'b1);
    a_pad_i = 8'h96; #2;
    b_pad_i = b_pad_o; #1;
    pulse_b();
    set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 driven bus captured", {24'd0, a_pad_o}, 32'h96);

    // R1: asynchronous reset mid-run
    rst_ni = 1'b0; #5;
    chk("R1 async clear B reg", {24'd0, a_pad_o}, 32'h00);
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R1 async clear A reg", {24'd0, b_pad_o}, 32'h00);
    rst_ni = 1'b1; #5;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule